// File: doc/BRIEF.md
# DWORD-to-QWORD Packing Write Buffer with Invalid Mask

This buffer sits on the write path from a 32/64-bit PCI data source toward a 64-bit memory writer. Incoming data beats are steered into two separately written 32-bit halves of a common entry: a low half and a high half. Each half also stores a 4-bit invalid nibble. The memory writer reads back one 64-bit word per pop, together with an 8-bit mask, and skips any DWORD whose nibble is all ones.

A transfer is announced by a one-cycle `start` pulse. That pulse carries the DWORD count and a flag that is set when the start address is not QWORD aligned (address bit 2 set). The buffer then places every accepted DWORD by itself. A misaligned start produces a filler in the low half. A transfer that ends on a low DWORD produces a filler in the high half. Because of this, the two halves stay in step, and a word becomes readable only when both of its halves exist.

In 32-bit mode, the half being written alternates between low and high, beginning with low. In 64-bit mode, one beat can fill both halves at once. The writer sees full and almost-full flags, and the reader sees an empty flag. A synchronous flush clears all of the buffer's state.

Top module: `dword_pack_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0 and `afull`=0.
- R2: With `wide`=0, the first accepted DWORD of an aligned transfer goes to the low half, and later DWORDs alternate between the halves. A low write needs `xfer` and `lo_ack` and takes its data from `din[31:0]`. A high write needs `xfer` and `hi_ack` and takes its data from `din[63:32]`. An acknowledge for the half that is not currently selected is ignored.
- R3: With `wide`=1, a beat that has both `lo_ack` and `hi_ack` set writes both halves and both nibbles in the same cycle. A beat with `hi_ack` only fills the high half of an entry whose low half is already written.
- R4: When `start` is high with `start_odd`=1, the low half of the next entry is written in that cycle as a filler, with data 0 and mask nibble 4'hF. The first DWORD of the transfer then goes to the high half.
- R5: When the last DWORD of a transfer (counted by `len`) lands in a low half, the high half of the same entry is written in the same cycle as a filler, with data 0 and mask nibble 4'hF.
- R6: A half that holds transfer data has mask nibble 4'h0. `rd_data` = {high half, low half} and `rd_mask` = {high nibble, low nibble}.
- R7: An entry becomes readable (`empty` falls) only in the cycle after its high half is written. A high write is ignored unless its entry already has a low half or receives one in the same cycle.
- R8: Beats are accepted from the cycle after `start`. Beats in the `start` cycle, and beats after `len` DWORDs have been accepted, are ignored.
- R9: `rd_data`/`rd_mask` show the oldest entry while `empty`=0. `rd_en` pops it at the clock edge. `rd_en` while `empty`=1 has no effect.
- R10: `full`=1 when DEPTH low halves are held, and then low writes are ignored. `afull`=1 when at least AF_LVL low halves are held.
- R11: `flush` clears both halves' pointers, the read pointer, the half select and the remaining count. In the next cycle `empty`=1 and `full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all pointers and transfer state |
| start | input | 1 | Transfer start pulse |
| start_odd | input | 1 | Start address is not QWORD aligned (valid with start) |
| wide | input | 1 | 1 = 64-bit beats, 0 = 32-bit alternating beats |
| len | input | LEN_W | DWORD count of the transfer (valid with start) |
| xfer | input | 1 | Data transfer strobe |
| lo_ack | input | 1 | Low DWORD lane of `din` is valid |
| hi_ack | input | 1 | High DWORD lane of `din` is valid |
| din | input | 64 | Beat data, low DWORD in [31:0], high in [63:32] |
| rd_en | input | 1 | Pop the oldest readable entry |
| rd_data | output | 64 | Oldest entry data |
| rd_mask | output | 8 | Oldest entry invalid nibbles, high in [7:4] |
| empty | output | 1 | No readable entry |
| full | output | 1 | All low halves occupied |
| afull | output | 1 | Low-half occupancy at or above AF_LVL |

## Verification
Every write-side effect, including fillers, is registered at the edge where the beat or `start` is sampled. The flags and the show-ahead read word therefore change one edge after the stimulus, and a pop moves the read word one edge after `rd_en`. The bench drives inputs on falling edges and compares outputs at the next falling edge, exactly one rising edge after each stimulus. R7 is checked in the cycle between a lone low write and its partner, where `empty` must still read 1. The expected words come from arithmetic on DWORD positions, with odd start plus index split into word and half, not from any model of the pointers.

// File: rtl/dword_pack_fifo.sv
module dword_pack_fifo #(
  parameter int DEPTH  = 128,
  parameter int AF_LVL = 120,
  parameter int LEN_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start,
  input  logic             start_odd,
  input  logic             wide,
  input  logic [LEN_W-1:0] len,
  input  logic             xfer,
  input  logic             lo_ack,
  input  logic             hi_ack,
  input  logic [63:0]      din,
  input  logic             rd_en,
  output logic [63:0]      rd_data,
  output logic [7:0]       rd_mask,
  output logic             empty,
  output logic             full,
  output logic             afull
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [31:0] lo_mem [DEPTH];
  logic [31:0] hi_mem [DEPTH];
  logic [3:0]  lo_msk [DEPTH];
  logic [3:0]  hi_msk [DEPTH];

  logic [PW-1:0]    wp_lo, wp_hi, rp;
  logic             sel_hi;
  logic [LEN_W-1:0] rem;

  wire [PW-1:0] lo_occ = wp_lo - rp;
  wire [PW-1:0] rd_cnt = wp_hi - rp;

  assign full  = (lo_occ == PW'(DEPTH));
  assign afull = (lo_occ >= PW'(AF_LVL));
  assign empty = (rd_cnt == '0);

  wire lead_pad = start & start_odd & ~full & ~flush;
  wire lo_dat   = xfer & lo_ack & (wide | ~sel_hi) & (rem != '0)
                & ~full & ~start & ~flush;
  wire hi_room  = (wp_hi != wp_lo) | lo_dat;
  wire hi_dat   = xfer & hi_ack & (wide | sel_hi) & (rem > LEN_W'(lo_dat))
                & hi_room & ~start & ~flush;
  wire tail_pad = lo_dat & ~hi_dat & (rem == LEN_W'(1));
  wire lo_we    = lead_pad | lo_dat;
  wire hi_we    = hi_dat | tail_pad;
  wire pop      = rd_en & ~empty & ~flush;

  always_ff @(posedge clk) begin
    if (lo_we) begin
      lo_mem[wp_lo[AW-1:0]] <= lead_pad ? 32'h0 : din[31:0];
      lo_msk[wp_lo[AW-1:0]] <= lead_pad ? 4'hF : 4'h0;
    end
    if (hi_we) begin
      hi_mem[wp_hi[AW-1:0]] <= tail_pad ? 32'h0 : din[63:32];
      hi_msk[wp_hi[AW-1:0]] <= tail_pad ? 4'hF : 4'h0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_lo  <= '0;
      wp_hi  <= '0;
      rp     <= '0;
      sel_hi <= 1'b0;
      rem    <= '0;
    end else if (flush) begin
      wp_lo  <= '0;
      wp_hi  <= '0;
      rp     <= '0;
      sel_hi <= 1'b0;
      rem    <= '0;
    end else begin
      if (lo_we) wp_lo <= wp_lo + 1'b1;
      if (hi_we) wp_hi <= wp_hi + 1'b1;
      if (pop)   rp    <= rp + 1'b1;
      if (start) begin
        sel_hi <= start_odd;
        rem    <= len;
      end else begin
        if (tail_pad)    sel_hi <= 1'b0;
        else if (lo_dat) sel_hi <= 1'b1;
        else if (hi_dat) sel_hi <= 1'b0;
        rem <= rem - LEN_W'(lo_dat) - LEN_W'(hi_dat);
      end
    end
  end

  assign rd_data = {hi_mem[rp[AW-1:0]], lo_mem[rp[AW-1:0]]};
  assign rd_mask = {hi_msk[rp[AW-1:0]], lo_msk[rp[AW-1:0]]};
endmodule

module dword_pack_fifo_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          rd_en,
  input logic          empty,
  input logic          full,
  input logic          afull,
  input logic [7:0]    rd_mask,
  input logic [PW-1:0] wp_lo,
  input logic [PW-1:0] wp_hi,
  input logic [PW-1:0] rp
);
  // R7
  hi_not_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(wp_hi - rp) <= PW'(wp_lo - rp));
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !flush) |=> $stable(rp));
  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !full));
  // R10
  full_afull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> afull);
  // R6
  mask_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> ((rd_mask[3:0] == 4'h0 || rd_mask[3:0] == 4'hF) &&
                (rd_mask[7:4] == 4'h0 || rd_mask[7:4] == 4'hF)));
  // R4 R5
  no_empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> (rd_mask != 8'hFF));
endmodule

bind dword_pack_fifo dword_pack_fifo_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .rd_en(rd_en),
  .empty(empty), .full(full), .afull(afull), .rd_mask(rd_mask),
  .wp_lo(wp_lo), .wp_hi(wp_hi), .rp(rp)
);

// File: tb/test_dword_pack_fifo.sv
module test_dword_pack_fifo;
  localparam int DEPTH = 8;
  localparam int AFL   = 6;
  localparam int LW    = 8;

  logic clk = 0, rst_n = 0, flush = 0, start = 0, start_odd = 0, wide = 0;
  logic [LW-1:0] len = '0;
  logic xfer = 0, lo_ack = 0, hi_ack = 0, rd_en = 0;
  logic [63:0] din = '0;
  logic [63:0] rd_data;
  logic [7:0]  rd_mask;
  logic empty, full, afull;

  int errors = 0, checks = 0, tid = 0;
  bit done = 0;
  logic [31:0] ed [64];
  logic [7:0]  em [64];
  int nexp;

  always #2 clk = ~clk;

  dword_pack_fifo #(.DEPTH(DEPTH), .AF_LVL(AFL), .LEN_W(LW)) i_dword_pack_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .start(start), .start_odd(start_odd),
    .wide(wide), .len(len), .xfer(xfer), .lo_ack(lo_ack), .hi_ack(hi_ack),
    .din(din), .rd_en(rd_en), .rd_data(rd_data), .rd_mask(rd_mask),
    .empty(empty), .full(full), .afull(afull));

  function automatic logic [31:0] dw(int t, int i);
    return {8'(t), 24'(i) + 24'h100};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic begin_xfer(bit w, bit odd, int n);
    @(negedge clk);
    start = 1; start_odd = odd; wide = w; len = LW'(n);
    @(negedge clk);
    start = 0;
    tid++;
  endtask

  // expected words: DWORD i sits at position odd+i
  task automatic build_exp(bit odd, int n);
    nexp = (odd + n + 1) / 2;
    for (int w = 0; w < nexp; w++) begin
      logic [31:0] lo, hi; logic [3:0] ml, mh;
      int il = 2*w - odd, ih = 2*w + 1 - odd;
      lo = (il >= 0 && il < n) ? dw(tid, il) : 32'h0;
      ml = (il >= 0 && il < n) ? 4'h0 : 4'hF;
      hi = (ih >= 0 && ih < n) ? dw(tid, ih) : 32'h0;
      mh = (ih >= 0 && ih < n) ? 4'h0 : 4'hF;
      ed[2*w] = lo; ed[2*w+1] = hi; em[w] = {mh, ml};
    end
  endtask

  task automatic send_beats(bit w, bit odd, int n);
    if (!w) begin
      for (int i = 0; i < n; i++) begin
        bit h = ((odd + i) % 2) == 1;
        xfer = 1; lo_ack = !h; hi_ack = h;
        din = h ? {dw(tid, i), 32'hDEAD0000} : {32'hDEAD0001, dw(tid, i)};
        @(negedge clk);
      end
    end else begin
      for (int wd = 0; wd < (odd + n + 1) / 2; wd++) begin
        int il = 2*wd - odd, ih = 2*wd + 1 - odd;
        xfer = 1;
        lo_ack = (il >= 0 && il < n);
        hi_ack = (ih >= 0 && ih < n);
        din = {dw(tid, ih), dw(tid, il)};
        @(negedge clk);
      end
    end
    xfer = 0; lo_ack = 0; hi_ack = 0;
  endtask

  task automatic drain(string req, int cnt);
    for (int w = 0; w < cnt; w++) begin
      chk({req, " not empty"}, {63'h0, empty}, 64'h0);
      chk({req, " data"}, rd_data, {ed[2*w+1], ed[2*w]});
      chk({req, " mask"}, {56'h0, rd_mask}, {56'h0, em[w]});
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
    end
    chk({req, " empty after drain"}, {63'h0, empty}, 64'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 empty", {63'h0, empty}, 64'h1);
    chk("R1 full", {63'h0, full}, 64'h0);
    chk("R1 afull", {63'h0, afull}, 64'h0);

    // R9 pop on empty ignored
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R9 empty pop", {63'h0, empty}, 64'h1);

    // sweep R2 R3 R4 R5 R6
    for (int w = 0; w < 2; w++)
      for (int o = 0; o < 2; o++)
        for (int n = 1; n <= 7; n++) begin
          begin_xfer(w[0], o[0], n);
          build_exp(o[0], n);
          send_beats(w[0], o[0], n);
          drain(w ? "R3 R4 R5 R6 wide" : "R2 R4 R5 R6 narrow", nexp);
        end

    // R7: lone low write not readable; R2 wrong-lane ack ignored
    begin_xfer(0, 0, 2);
    build_exp(0, 2);
    xfer = 1; hi_ack = 1; lo_ack = 0; din = 64'hBAD0BAD0_BAD1BAD1;
    @(negedge clk);
    xfer = 1; lo_ack = 1; hi_ack = 0; din = {32'hDEAD0001, dw(tid, 0)};
    @(negedge clk);
    xfer = 0; lo_ack = 0;
    chk("R7 half entry empty", {63'h0, empty}, 64'h1);
    xfer = 1; lo_ack = 1; din = {32'hBEEF0000, 32'hBEEF0001};
    @(negedge clk);
    chk("R7 wrong-lane low ignored", {63'h0, empty}, 64'h1);
    xfer = 1; lo_ack = 0; hi_ack = 1; din = {dw(tid, 1), 32'hDEAD0002};
    @(negedge clk);
    xfer = 0; hi_ack = 0;
    // R8: beat after length ignored
    xfer = 1; lo_ack = 1; hi_ack = 1; din = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    xfer = 0; lo_ack = 0; hi_ack = 0;
    drain("R2 R7 R8", 1);

    // R8: beat in start cycle ignored
    @(negedge clk);
    start = 1; start_odd = 0; wide = 1; len = LW'(2);
    xfer = 1; lo_ack = 1; hi_ack = 1; din = 64'h1111_1111_2222_2222;
    @(negedge clk);
    start = 0; xfer = 0; lo_ack = 0; hi_ack = 0;
    tid++;
    chk("R8 start-cycle beat ignored", {63'h0, empty}, 64'h1);
    build_exp(0, 2);
    send_beats(1, 0, 2);
    drain("R8", 1);

    // R10 full / afull, R11 flush
    begin_xfer(1, 0, 40);
    for (int k = 0; k < DEPTH + 1; k++) begin
      xfer = 1; lo_ack = 1; hi_ack = 1; din = {dw(tid, 2*k+1), dw(tid, 2*k)};
      @(negedge clk);
      xfer = 0; lo_ack = 0; hi_ack = 0;
      if (k == AFL - 2) chk("R10 afull below level", {63'h0, afull}, 64'h0);
      if (k == AFL - 1) chk("R10 afull at level", {63'h0, afull}, 64'h1);
      if (k == DEPTH - 2) chk("R10 not full", {63'h0, full}, 64'h0);
      if (k == DEPTH - 1) chk("R10 full", {63'h0, full}, 64'h1);
    end
    nexp = DEPTH;
    for (int k = 0; k < DEPTH; k++) begin
      ed[2*k] = dw(tid, 2*k); ed[2*k+1] = dw(tid, 2*k+1); em[k] = 8'h00;
    end
    drain("R10 overflow beat ignored", DEPTH);
    xfer = 1; lo_ack = 1; hi_ack = 1; din = 64'h0;
    @(negedge clk);
    xfer = 0; lo_ack = 0; hi_ack = 0;
    chk("R11 pre-flush data", {63'h0, empty}, 64'h0);
    flush = 1; @(negedge clk); flush = 0;
    chk("R11 empty", {63'h0, empty}, 64'h1);
    chk("R11 full", {63'h0, full}, 64'h0);
    // remaining count cleared: beat without start ignored
    xfer = 1; lo_ack = 1; hi_ack = 1; @(negedge clk);
    xfer = 0; lo_ack = 0; hi_ack = 0;
    chk("R11 remaining cleared", {63'h0, empty}, 64'h1);
    begin_xfer(0, 1, 3);
    build_exp(1, 3);
    send_beats(0, 1, 3);
    drain("R11 after flush", nexp);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule